// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps transitions on an asynchronous input pin. The pin is first brought into the clock domain through a synchronizer. The edges that come out of it are then qualified by a 4-bit mode field, which selects rising edges, falling edges, both edges, or every 4th or 16th rising edge. Each qualifying event latches the current value of an external free-running time base into a four-entry capture FIFO. Software or a downstream engine reads that FIFO in arrival order.

An event postscaler counts qualifying capture events. It raises a one-cycle interrupt request once a programmed number of events has occurred. A capture that arrives while the FIFO is full is dropped and sets a sticky overflow flag. A postscale setting above three events therefore overflows the FIFO unless the reader keeps up.

Top module: `icap_unit`

## Requirements
- R1: The pin passes through two synchronizer flops and one edge-history flop. A pin change driven before clock edge k is captured at edge k+2, and the stored word is the timeBase value present at that edge.
- R2: Mode 4'b0001 captures on every rising edge. Mode 4'b0010 captures on every falling edge.
- R3: Modes 4'b0000 and 4'b0011 both capture on every rising edge and on every falling edge.
- R4: Mode 4'b0100 captures on every 4th rising edge, and mode 4'b0101 captures on every 16th rising edge. The prescale count starts at zero after enable or a mode change.
- R5: Modes 4'b0110, 4'b0111 and every code with bit 3 set produce no captures and no interrupt.
- R6: With evtPost = N, irq is high for exactly one cycle on the (N+1)th capture event, and the count then restarts from zero.
- R7: The FIFO holds 4 entries and returns them oldest first. rdData shows the oldest entry while fifoEmpty is 0. rdEn pops one entry per cycle, and rdEn while empty has no effect. fifoEmpty is 1 when no entries remain.
- R8: A capture while the FIFO is full, with no pop in the same cycle, is discarded and sets overflow. overflow then stays 1 until the unit is disabled. A discarded capture still counts as an event for the postscaler.
- R9: While enable is 0, no captures or interrupts occur, the FIFO is flushed and overflow is cleared.
- R10: Any change of captMode clears the edge prescale counter and the event postscale counter.
- R11: After reset, fifoEmpty is 1, overflow is 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Unit enable; low flushes and clears |
| pinIn | input | 1 | Raw asynchronous input pin |
| timeBase | input | TB_W | Free-running time base value |
| captMode | input | 4 | Edge qualification and prescale select |
| evtPost | input | 4 | Events per interrupt, minus one |
| rdEn | input | 1 | Pop the oldest FIFO entry |
| rdData | output | TB_W | Oldest captured time stamp |
| fifoEmpty | output | 1 | No entries held |
| overflow | output | 1 | Sticky flag for a discarded capture |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions assume that rdEn, captMode, evtPost and enable are synchronous to clk. They also assume that captMode does not change during the same cycle a pin edge emerges from the synchronizer that the bench cares about. Only pinIn is treated as asynchronous.

The bench changes every input half a period after the rising edge. It keeps each pin level for four cycles, so every transition is seen once by the edge detector. It lets the pipeline settle for several cycles after each pulse train before it changes the mode, the postscale value or enable.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } icap_strobe_t;

  typedef struct packed {
    logic       onRise;
    logic       onFall;
    logic [3:0] preLimit;   // 0: no prescale, else last count value
  } edge_sel_t;

  localparam logic [3:0] MODE_EDGE_DET = 4'b0000;
  localparam logic [3:0] MODE_RISE     = 4'b0001;
  localparam logic [3:0] MODE_FALL     = 4'b0010;
  localparam logic [3:0] MODE_BOTH     = 4'b0011;
  localparam logic [3:0] MODE_RISE4    = 4'b0100;
  localparam logic [3:0] MODE_RISE16   = 4'b0101;

  function automatic edge_sel_t decodeMode(input logic [3:0] m);
    edge_sel_t s;
    s = '0;
    case (m)
      MODE_EDGE_DET, MODE_BOTH: begin s.onRise = 1'b1; s.onFall = 1'b1; end
      MODE_RISE:   s.onRise = 1'b1;
      MODE_FALL:   s.onFall = 1'b1;
      MODE_RISE4:  begin s.onRise = 1'b1; s.preLimit = 4'd3;  end
      MODE_RISE16: begin s.onRise = 1'b1; s.preLimit = 4'd15; end
      default:     s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/icap_ctrl.sv
module icap_ctrl
  import icap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         pinIn,
  input  logic [3:0]   captMode,
  input  logic [3:0]   evtPost,
  input  logic         rdEn,
  input  logic         fifoEmpty,
  output icap_strobe_t strb,
  output logic         irq
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   pinS;
  logic [3:0]             modeQ;
  logic [3:0]             preCnt;
  logic [3:0]             postCnt;
  logic                   riseDet, fallDet, clrCnt, evt;
  edge_sel_t              sel;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      end
    end
  endgenerate

  assign pinS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ <= 1'b0;
      modeQ <= '0;
    end else begin
      prevQ <= pinS;
      modeQ <= captMode;
    end
  end

  assign riseDet = pinS & ~prevQ;
  assign fallDet = ~pinS & prevQ;
  assign sel     = decodeMode(captMode);
  assign clrCnt  = !enable || (captMode != modeQ);

  always_comb begin
    evt = 1'b0;
    if (!clrCnt) begin
      if (sel.preLimit == 4'd0)
        evt = (sel.onRise & riseDet) | (sel.onFall & fallDet);
      else
        evt = riseDet && (preCnt == sel.preLimit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clrCnt) begin
      preCnt <= '0;
    end else if (sel.preLimit != 4'd0 && riseDet) begin
      preCnt <= (preCnt == sel.preLimit) ? 4'd0 : preCnt + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clrCnt) begin
      postCnt <= '0;
      irq     <= 1'b0;
    end else if (evt) begin
      irq     <= (postCnt == evtPost);
      postCnt <= (postCnt == evtPost) ? 4'd0 : postCnt + 4'd1;
    end else begin
      irq     <= 1'b0;
    end
  end

  always_comb begin
    strb.push  = evt;
    strb.pop   = rdEn && !fifoEmpty && enable;
    strb.flush = !enable;
  end

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (captMode[3] || captMode[2:1] == 2'b11) |-> !strb.push); // R5

  AST_IRQ_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(strb.push)); // R6

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !irq); // R9

endmodule

// File: rtl/icap_datapath.sv
module icap_datapath
  import icap_pkg::*;
#(
  parameter int TB_W       = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  icap_strobe_t    strb,
  input  logic [TB_W-1:0] timeBase,
  output logic [TB_W-1:0] rdData,
  output logic            fifoEmpty,
  output logic            overflow
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic [TB_W-1:0]  mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             full, doPush, doPop;

  assign full      = (count == FULL_CNT);
  assign doPop     = strb.pop && (count != '0);
  assign doPush    = strb.push && (!full || doPop);
  assign fifoEmpty = (count == '0);
  assign rdData    = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !strb.flush) mem[wrPtr] <= timeBase;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strb.push && !doPush) overflow <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !strb.flush) |=> overflow); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (fifoEmpty && !overflow)); // R9

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push && !strb.flush && !fifoEmpty) |=> (count == $past(count) - 1'b1)); // R7

endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int TB_W        = 16,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            pinIn,
  input  logic [TB_W-1:0] timeBase,
  input  logic [3:0]      captMode,
  input  logic [3:0]      evtPost,
  input  logic            rdEn,
  output logic [TB_W-1:0] rdData,
  output logic            fifoEmpty,
  output logic            overflow,
  output logic            irq
);

  icap_strobe_t strb;

  icap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .pinIn     (pinIn),
    .captMode  (captMode),
    .evtPost   (evtPost),
    .rdEn      (rdEn),
    .fifoEmpty (fifoEmpty),
    .strb      (strb),
    .irq       (irq)
  );

  icap_datapath #(.TB_W(TB_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .timeBase  (timeBase),
    .rdData    (rdData),
    .fifoEmpty (fifoEmpty),
    .overflow  (overflow)
  );

endmodule

// File: tb/test_icap_unit.sv
`timescale 1ns/1ps
module test_icap_unit;

  localparam int TB_W = 16;
  localparam int DEPTH = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            enable = 1'b0;
  logic            pinIn = 1'b0;
  logic [TB_W-1:0] timeBase = '0;
  logic [3:0]      captMode = 4'b0001;
  logic [3:0]      evtPost = 4'd15;
  logic            rdEn = 1'b0;
  logic [TB_W-1:0] rdData;
  logic            fifoEmpty, overflow, irq;

  int checks = 0;
  int fails = 0;
  int irqSeen = 0;
  bit running = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  always @(negedge clk) timeBase <= timeBase + 1'b1;

  icap_unit #(.TB_W(TB_W), .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) i_icap_unit (
    .clk(clk), .rstN(rstN), .enable(enable), .pinIn(pinIn), .timeBase(timeBase),
    .captMode(captMode), .evtPost(evtPost), .rdEn(rdEn), .rdData(rdData),
    .fifoEmpty(fifoEmpty), .overflow(overflow), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [TB_W-1:0] q[$];
  bit   s1, s2, s3, ovfM, irqM;
  int   preM, postM;
  logic [3:0] mPrev;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); s1 = 0; s2 = 0; s3 = 0; ovfM = 0; irqM = 0;
      preM = 0; postM = 0; mPrev = 4'b0000;
    end else begin
      bit rise, fall, ev, doPop;
      rise = s2 && !s3;
      fall = !s2 && s3;
      ev = 0;
      if (!enable || captMode != mPrev) begin
        preM = 0; postM = 0; irqM = 0;
        if (!enable) begin q.delete(); ovfM = 0; end
      end else begin
        case (captMode)
          4'b0000, 4'b0011: ev = rise || fall;
          4'b0001: ev = rise;
          4'b0010: ev = fall;
          4'b0100, 4'b0101: if (rise) begin
            int lim;
            lim = (captMode == 4'b0100) ? 4 : 16;
            preM++;
            if (preM == lim) begin ev = 1; preM = 0; end
          end
          default: ev = 0;
        endcase
        doPop = rdEn && q.size() > 0;
        irqM = 0;
        if (ev) begin
          if (postM == int'(evtPost)) begin irqM = 1; postM = 0; end
          else postM++;
        end
        if (doPop) void'(q.pop_front());
        if (ev) begin
          if (q.size() < DEPTH) q.push_back(timeBase);
          else ovfM = 1;
        end
      end
      mPrev = captMode;
      s3 = s2; s2 = s1; s1 = pinIn;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk(fifoEmpty == (q.size() == 0), "R7", "fifoEmpty", fifoEmpty, q.size() == 0);
      chk(overflow == ovfM, "R8", "overflow", overflow, ovfM);
      chk(irq == irqM, "R6", "irq", irq, irqM);
      if (q.size() > 0) chk(rdData == q[0], "R1", "rdData", rdData, q[0]);
      if (irq) irqSeen++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pinIn = 1'b1; step(4);
      pinIn = 1'b0; step(4);
    end
    step(6);
  endtask

  task automatic drain(output int n);
    n = 0;
    while (!fifoEmpty) begin
      rdEn = 1'b1; step(1); rdEn = 1'b0; n++;
    end
    step(1);
  endtask

  task automatic setMode(input logic [3:0] m);
    captMode = m; step(3);
  endtask

  task automatic reEnable();
    enable = 1'b0; step(2); enable = 1'b1; step(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [TB_W-1:0] v;
    step(3);
    chk(fifoEmpty == 1'b1, "R11", "reset fifoEmpty", fifoEmpty, 1);
    chk(overflow == 1'b0, "R11", "reset overflow", overflow, 0);
    chk(irq == 1'b0, "R11", "reset irq", irq, 0);
    rstN = 1'b1; step(1);
    running = 1; enable = 1'b1; step(2);

    // R2 rising / falling
    setMode(4'b0001); pulses(3); drain(n);
    chk(n == 3, "R2", "rising captures", n, 3);
    setMode(4'b0010); pulses(2); drain(n);
    chk(n == 2, "R2", "falling captures", n, 2);
    // R3 both edges
    setMode(4'b0011); pulses(2); drain(n);
    chk(n == 4, "R3", "both-edge captures", n, 4);
    setMode(4'b0000); pulses(1); drain(n);
    chk(n == 2, "R3", "edge-detect captures", n, 2);
    // R4 prescaled
    setMode(4'b0100); pulses(9); drain(n);
    chk(n == 2, "R4", "every 4th rising", n, 2);
    setMode(4'b0101); pulses(17); drain(n);
    chk(n == 1, "R4", "every 16th rising", n, 1);
    // R5 reserved codes
    evtPost = 4'd0;
    setMode(4'b0110); pulses(2);
    setMode(4'b0111); pulses(2);
    setMode(4'b1000); pulses(2);
    setMode(4'b1111); pulses(2);
    chk(fifoEmpty == 1'b1, "R5", "reserved captures", !fifoEmpty, 0);
    chk(irqSeen == 0, "R5", "reserved irq", irqSeen, 0);
    evtPost = 4'd15;

    // R10 prescale cleared by mode change
    setMode(4'b0100); pulses(3);
    setMode(4'b0101); setMode(4'b0100); pulses(3); drain(n);
    chk(n == 0, "R10", "prescale cleared", n, 0);
    // R10 postscale cleared by mode change
    evtPost = 4'd3; irqSeen = 0;
    setMode(4'b0001); pulses(2);
    setMode(4'b0011); pulses(1);
    chk(irqSeen == 0, "R10", "postscale cleared", irqSeen, 0);
    pulses(1);
    chk(irqSeen == 1, "R10", "irq after 4 new events", irqSeen, 1);
    drain(n); reEnable();

    // R6 postscaler and R8 overflow
    evtPost = 4'd2; irqSeen = 0;
    setMode(4'b0001); pulses(7);
    chk(irqSeen == 2, "R6", "irq pulses for 7 events", irqSeen, 2);
    chk(overflow == 1'b1, "R8", "overflow set", overflow, 1);
    drain(n);
    chk(n == DEPTH, "R8", "kept entries", n, DEPTH);
    chk(overflow == 1'b1, "R8", "overflow sticky", overflow, 1);
    // R7 read when empty ignored
    rdEn = 1'b1; step(2); rdEn = 1'b0;
    pulses(1);
    chk(fifoEmpty == 1'b0, "R7", "entry after empty read", fifoEmpty, 0);
    drain(n);
    chk(n == 1, "R7", "single entry", n, 1);

    // R9 disable
    pulses(2);
    enable = 1'b0; step(2);
    chk(fifoEmpty == 1'b1 && overflow == 1'b0, "R9", "flush on disable", {fifoEmpty, overflow}, 2);
    irqSeen = 0; evtPost = 4'd0;
    pulses(3);
    chk(fifoEmpty == 1'b1, "R9", "no capture disabled", !fifoEmpty, 0);
    chk(irqSeen == 0, "R9", "no irq disabled", irqSeen, 0);
    enable = 1'b1; step(3);

    // R1 capture latency and value
    evtPost = 4'd15;
    pinIn = 1'b1; v = timeBase; step(5);
    chk(rdData == v + 2, "R1", "captured stamp", rdData, v + 2);
    pinIn = 1'b0; step(6); drain(n);

    running = 0; done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule